// File: doc/BRIEF.md
# Beat Count Bit Harvester

This block turns each captured beat count from an oscillator-difference entropy source into random output bits. Only the lowest few bits of a count carry usable entropy, so everything above them is thrown away. The lowest three bits are released unchanged. The next bit up is biased when taken alone, so it is debiased across pairs of counts with a von Neumann corrector. On average each count yields about three and a quarter bits.

Counts arrive as a word with a one-cycle valid strobe. The source counter restarts after every capture, so each count is treated as an independent sample. Output bits leave one at a time on a valid/ready stream that is buffered in a small FIFO. A count is handled as a whole: if the FIFO has no room for all the bits it would produce, the whole count is discarded and a saturating drop counter goes up by one.

Top module: `bitHarvester`

## Requirements
- R1: Count bits above bit 3 have no effect on the output stream, the drop counter or the pairing state.
- R2: For every accepted count, bits 0, 1 and 2 are written to the stream in that order, bit 0 first, with no transformation.
- R3: Bit 3 of accepted counts is paired across two consecutive accepted counts. The first bit of a pair is held. When the second arrives, the pair (0, 1) emits 0 and the pair (1, 0) emits 1, so the emitted value equals the first bit. Equal pairs emit nothing. An emitted bit follows the three direct bits of the second count, and the pair is then consumed.
- R4: outBit is valid while outValid is 1. A bit is removed only on a cycle where outValid and outReady are both 1. While outReady is 0, outValid and outBit stay unchanged. Bits leave in the order they were written.
- R5: The FIFO holds 8 bits. A count is accepted only if the free space, measured before any pop in the same cycle, is at least the number of bits the count produces (3, or 4 when it completes an unequal pair). Otherwise the whole count is dropped: nothing is written and the held half-pair is unchanged.
- R6: Every dropped count increments dropCount by one, and dropCount saturates at its all-ones value.
- R7: Reset empties the FIFO (outValid is 0), clears dropCount to 0 and discards any held half-pair, so the first count after reset always starts a new pair.
- R8: The FIFO occupancy never exceeds its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countValid | input | 1 | One-cycle strobe marking a new count |
| countIn | input | CNT_W (10) | Captured beat count |
| outReady | input | 1 | Consumer accepts the current output bit |
| outValid | output | 1 | An output bit is available |
| outBit | output | 1 | Current random output bit |
| dropCount | output | DROP_W (8) | Saturating count of discarded samples |

## Verification
On every cycle the assertions check that occupancy stays within the FIFO depth, that a stalled output holds its value, that a dropped count writes nothing and leaves the half-pair untouched, that a drop moves the counter up by exactly one, and that an accepted second count consumes the pair. The order of bits within the stream, the corrector's output for each of the four pair patterns, the fact that high count bits have no effect, and the fresh pairing after a reset can only be shown by the bench's scenarios. For these, the bench sweeps every combination of low nibbles across two consecutive counts with random upper bits, and compares each drained bit with a model built from the requirements.

// File: rtl/bitHarvesterPkg.sv
package bitHarvesterPkg;

  // Strobes issued by the control to the datapath for one input cycle
  typedef struct packed {
    logic accept;     // write this count's bits
    logic drop;       // discard this count, bump the drop counter
    logic holdLoad;   // store the debiased bit as the first half of a pair
    logic holdClear;  // pair completed, release the held bit
    logic vnEmit;     // unequal pair: write the corrector bit after the direct bits
  } harvStrobe_t;

endpackage

// File: rtl/bitHarvesterCtrl.sv
module bitHarvesterCtrl
  import bitHarvesterPkg::*;
#(
  parameter int DIRECT_N = 3,
  parameter int DEPTH    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           countValid,
  input  logic                           debBit,
  input  logic                           holdValid,
  input  logic                           holdBit,
  input  logic [$clog2(DEPTH+1)-1:0]     level,
  output harvStrobe_t                    st
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             pairDiffers;
  logic [LVL_W-1:0] freeSlots;
  logic [LVL_W-1:0] needSlots;
  logic             fits;

  always_comb begin
    pairDiffers = holdValid && (debBit != holdBit);
    freeSlots   = LVL_W'(DEPTH) - level;
    needSlots   = LVL_W'(DIRECT_N) + LVL_W'(pairDiffers);
    fits        = (freeSlots >= needSlots);

    st.accept    = countValid && fits;
    st.drop      = countValid && !fits;
    st.holdLoad  = st.accept && !holdValid;
    st.holdClear = st.accept && holdValid;
    st.vnEmit    = st.accept && pairDiffers;
  end

  // An accepted count that meets a held bit must use up the pair
  AST_PAIR_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    (st.accept && holdValid) |=> !holdValid); // R3

  // A first-half count must leave a half-pair behind
  AST_PAIR_OPENED: assert property (@(posedge clk) disable iff (!rstN)
    (st.accept && !holdValid) |=> (holdValid && holdBit == $past(debBit))); // R3

endmodule

// File: rtl/bitHarvesterDatapath.sv
module bitHarvesterDatapath
  import bitHarvesterPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DIRECT_N = 3,
  parameter int DEPTH    = 8,
  parameter int DROP_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  harvStrobe_t                st,
  input  logic [CNT_W-1:0]           countIn,
  input  logic                       outReady,
  output logic                       outValid,
  output logic                       outBit,
  output logic                       holdValid,
  output logic                       holdBit,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic [DROP_W-1:0]          dropCount
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [LVL_W-1:0] pushN;
  logic             pop;

  assign outValid = (level != '0);
  assign outBit   = mem[rdPtr];
  assign pop      = outValid && outReady;

  always_comb begin
    pushN = '0;
    if (st.accept) pushN = LVL_W'(DIRECT_N) + LVL_W'(st.vnEmit);
  end

  // Bit store: direct bits first in ascending order, corrector bit last
  always_ff @(posedge clk) begin
    for (int i = 0; i <= DIRECT_N; i++) begin
      if (st.accept && (i < DIRECT_N || st.vnEmit)) begin
        mem[wrPtr + PTR_W'(i)] <= (i < DIRECT_N) ? countIn[i] : holdBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(pop);
      level <= level + pushN - LVL_W'(pop);
    end
  end

  // Held half-pair of the debiased bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdBit   <= 1'b0;
    end else if (st.holdClear) begin
      holdValid <= 1'b0;
    end else if (st.holdLoad) begin
      holdValid <= 1'b1;
      holdBit   <= countIn[DIRECT_N];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCount <= '0;
    end else if (st.drop && dropCount != '1) begin
      dropCount <= dropCount + 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBit))); // R4

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    st.drop |=> (level <= $past(level) && $stable(holdValid) && $stable(holdBit))); // R5

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (st.drop && dropCount != '1) |=> dropCount == $past(dropCount) + 1'b1); // R6

  AST_DROP_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount == '1) |=> dropCount == '1); // R6

endmodule

// File: rtl/bitHarvester.sv
module bitHarvester
  import bitHarvesterPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DIRECT_N = 3,
  parameter int DEPTH    = 8,
  parameter int DROP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countValid,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              outReady,
  output logic              outValid,
  output logic              outBit,
  output logic [DROP_W-1:0] dropCount
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  harvStrobe_t      st;
  logic             holdValid;
  logic             holdBit;
  logic [LVL_W-1:0] level;

  bitHarvesterCtrl #(
    .DIRECT_N (DIRECT_N),
    .DEPTH    (DEPTH)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .countValid (countValid),
    .debBit     (countIn[DIRECT_N]),
    .holdValid  (holdValid),
    .holdBit    (holdBit),
    .level      (level),
    .st         (st)
  );

  bitHarvesterDatapath #(
    .CNT_W    (CNT_W),
    .DIRECT_N (DIRECT_N),
    .DEPTH    (DEPTH),
    .DROP_W   (DROP_W)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .countIn   (countIn),
    .outReady  (outReady),
    .outValid  (outValid),
    .outBit    (outBit),
    .holdValid (holdValid),
    .holdBit   (holdBit),
    .level     (level),
    .dropCount (dropCount)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rstN |=> (!outValid && dropCount == '0 && !holdValid)); // R7

endmodule

// File: tb/bitHarvester_test.sv
module bitHarvester_test;

  localparam int CNT_W = 10;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             countValid = 1'b0;
  logic [CNT_W-1:0] countIn = '0;
  logic             outReady = 1'b0;
  logic             outValid;
  logic             outBit;
  logic [7:0]       dropCount;

  int nChecks = 0;
  int nFails  = 0;

  // Bench model state
  bit expQ[$];
  int mLevel = 0;
  bit mHeld  = 0;
  bit mHeldBit = 0;
  int mDrops = 0;

  always #2 clk = ~clk;

  bitHarvester uut (
    .clk(clk), .rstN(rstN), .countValid(countValid), .countIn(countIn),
    .outReady(outReady), .outValid(outValid), .outBit(outBit), .dropCount(dropCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Sends one count (outReady held low by the caller) and updates the model
  task automatic sendCount(input logic [CNT_W-1:0] v);
    int need;
    bit b3;
    @(negedge clk);
    countValid = 1'b1;
    countIn    = v;
    b3   = v[3];
    need = 3 + ((mHeld && b3 != mHeldBit) ? 1 : 0);
    if (need <= DEPTH - mLevel) begin
      for (int i = 0; i < 3; i++) expQ.push_back(v[i]);   // R2
      if (mHeld) begin
        if (b3 != mHeldBit) expQ.push_back(mHeldBit);      // R3
        mHeld = 0;
      end else begin
        mHeld = 1; mHeldBit = b3;
      end
      mLevel += need;
    end else begin
      if (mDrops < 255) mDrops++;                          // R5 R6
    end
    @(negedge clk);
    countValid = 1'b0;
  endtask

  task automatic drain(input string req);
    outReady = 1'b1;
    while (expQ.size() > 0) begin
      chk(outValid === 1'b1, req, outValid, 1);
      chk(outBit === expQ[0], req, outBit, expQ[0]);
      void'(expQ.pop_front());
      @(negedge clk);
    end
    outReady = 1'b0;
    mLevel = 0;
    chk(outValid === 1'b0, {req, " R4 empty after drain"}, outValid, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
    mLevel = 0; mHeld = 0; mDrops = 0;
  endtask

  initial begin
    #(4ns * 200000);
    nFails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R7: reset state
    chk(outValid === 1'b0, "R7 outValid after reset", outValid, 0);
    chk(dropCount === 8'd0, "R7 dropCount after reset", dropCount, 0);

    // R1 R2 R3: every low-nibble pair, random upper bits
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        sendCount({6'($urandom), 4'(a)});
        sendCount({6'($urandom), 4'(b)});
        drain("R1 R2 R3 pair sweep");
      end
    end
    chk(dropCount === 8'd0, "R5 no drop in sweep", dropCount, 0);

    // R4: stall holds the head bit
    sendCount(10'h3A5);
    begin
      logic held;
      held = outBit;
      repeat (3) @(negedge clk);
      chk(outValid === 1'b1, "R4 stall valid", outValid, 1);
      chk(outBit === held, "R4 stall stable", outBit, held);
    end
    sendCount(10'h00B);
    drain("R4 order after stall");

    // R5 R6: overfill, drops leave pairing untouched
    sendCount(10'h000);
    sendCount(10'h00F);
    sendCount(10'h007);
    sendCount(10'h008);
    chk(dropCount === 8'(mDrops), "R6 drop count", dropCount, mDrops);
    chk(mDrops == 2, "R5 expected drops", mDrops, 2);
    drain("R5 after drops");
    sendCount(10'h008);
    sendCount(10'h3F0);
    drain("R5 pairing after drops");

    // R6: saturation
    repeat (3) sendCount(10'h000);
    for (int k = 0; k < 260; k++) sendCount(10'h001);
    chk(dropCount === 8'hFF, "R6 saturate", dropCount, 255);
    drain("R6 contents after saturation");

    // R7: reset discards a held half-pair
    doReset();
    sendCount(10'h008);
    doReset();
    chk(outValid === 1'b0, "R7 empty after mid reset", outValid, 0);
    chk(dropCount === 8'd0, "R7 drops cleared", dropCount, 0);
    sendCount(10'h000);
    sendCount(10'h000);
    sendCount(10'h004);
    sendCount(10'h00E);
    drain("R7 fresh pairing");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule